// File: doc/BRIEF.md
# DRAM Refresh Scheduler and Initializer

This block generates the refresh traffic for a dynamic RAM that keeps its own refresh row counter and refreshes a row whenever the column strobe falls before the row strobe. Out of reset it first waits out the power-up delay. It then issues a fixed number of wake-up refresh cycles on its own, without asking for the bus, and only then raises `init_done` to release normal traffic.

After initialization a free-running interval timer marks each point where a refresh falls due. The interval is the refresh window divided by the number of rows. A parameter selects the standard window or the low-power window. Due refreshes are counted in a small saturating backlog. While the backlog is non-empty and no refresh is running, `rfsh_req` asks the main memory controller for the bus. When the controller answers with `rfsh_gnt`, the block drives the row strobe, the column strobe and the write-enable itself for one complete refresh cycle, and pulses `rfsh_done` at the end. The write-enable is held high throughout, so the device never latches its internal test mode.

All strobe timings are given in nanoseconds and turned into clock cycles from the clock period parameter. No address pins are driven, because the device supplies the row itself.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is applied, `ras_n`, `cas_n` and `we_n` are high and `rfsh_req`, `rfsh_done` and `init_done` are low.
- R2: No strobe goes low until at least ceil(STARTUP_NS / CLK_NS) cycles after reset is released.
- R3: After the startup delay, exactly INIT_REFS (default 8) refresh cycles run with `rfsh_gnt` held low. `init_done` then rises and stays high until reset.
- R4: In every refresh cycle `cas_n` falls while `ras_n` is high and has been high for at least one cycle. `cas_n` then stays low for at least ceil(5 ns / CLK_NS) cycles before `ras_n` falls.
- R5: `ras_n` stays low for exactly max(ceil(50 ns / CLK_NS), CAS-hold + 1) cycles. `cas_n` rises only while `ras_n` is low, at least ceil(10 ns / CLK_NS) cycles after `ras_n` fell.
- R6: Between two refresh cycles `ras_n` is high for at least max(ceil(30 ns / CLK_NS), ceil(90 ns / CLK_NS) − row-low cycles) cycles, and successive `ras_n` falls are at least ceil(90 ns / CLK_NS) cycles apart.
- R7: `we_n` is high whenever `ras_n` falls, so no test mode entry occurs.
- R8: With the grant held high after initialization, successive `ras_n` falls are at most floor(WINDOW_NS / ROWS / CLK_NS) cycles apart. WINDOW_NS is the standard window when LOW_POWER = 0 and the low-power window otherwise. Every window therefore holds at least ROWS refreshes.
- R9: `rfsh_req` is high only after `init_done`, only while no refresh is running, and only while refreshes are pending. With the grant low, no refresh cycle starts after `init_done`.
- R10: Pending refreshes are counted up to BACKLOG_MAX (default 8) and no further. After a long denial, exactly BACKLOG_MAX refresh cycles follow the grant and `rfsh_req` then drops.
- R11: A refresh cycle starts (`cas_n` falls) in the cycle directly after a cycle in which `rfsh_req` and `rfsh_gnt` are both high, and only then once `init_done` is high.
- R12: `rfsh_done` is a one-cycle pulse, exactly setup + row-low + precharge cycles after the `cas_n` fall of the same refresh cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rfsh_gnt | input | 1 | Bus grant from the main controller |
| rfsh_req | output | 1 | Refresh bus request |
| rfsh_done | output | 1 | One-cycle pulse at the end of each refresh cycle |
| init_done | output | 1 | High once the wake-up sequence is complete |
| ras_n | output | 1 | Row strobe drive, active low |
| cas_n | output | 1 | Column strobe drive, active low |
| we_n | output | 1 | Write-enable drive, held high |

## Verification
With a 20 ns clock, `cas_n` falls one cycle after the cycle in which request and grant are both seen high. `ras_n` falls one cycle after that, `cas_n` rises one cycle later again, `ras_n` rises three cycles after its fall, and `rfsh_done` arrives six cycles after the `cas_n` fall. A backlog increment shows up as a request one cycle after the timer expires. The bench drives inputs shortly after the rising edge and samples at the falling edge, so a result due at edge n is read at the half cycle after it. Every interval is measured in counted falling edges from the event that caused it. Denial windows are placed a known offset after timer expiry, so that no new due refresh lands inside a counted window.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_SETUP,
    SQ_HOLD,
    SQ_ACT,
    SQ_PRE
  } sq_state_e;

  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer #(
  parameter int STARTUP_CYC  = 10000,
  parameter int INTERVAL_CYC = 781
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic startup_over,
  output logic tick
);
  localparam int SU_W = (STARTUP_CYC  > 1) ? $clog2(STARTUP_CYC + 1)  : 1;
  localparam int IV_W = (INTERVAL_CYC > 1) ? $clog2(INTERVAL_CYC + 1) : 1;

  logic [SU_W-1:0] su_cnt_q, su_cnt_d;
  logic            su_over_q, su_over_d;
  logic [IV_W-1:0] iv_cnt_q, iv_cnt_d;

  always_comb begin
    su_cnt_d  = su_cnt_q;
    su_over_d = su_over_q;
    if (!su_over_q) begin
      if (su_cnt_q == SU_W'(STARTUP_CYC - 1)) begin
        su_over_d = 1'b1;
      end else begin
        su_cnt_d = su_cnt_q + 1'b1;
      end
    end
  end

  always_comb begin
    iv_cnt_d = iv_cnt_q;
    if (run) begin
      if (iv_cnt_q == '0) begin
        iv_cnt_d = IV_W'(INTERVAL_CYC - 1);
      end else begin
        iv_cnt_d = iv_cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      su_cnt_q  <= '0;
      su_over_q <= 1'b0;
      iv_cnt_q  <= IV_W'(INTERVAL_CYC - 1);
    end else begin
      su_cnt_q  <= su_cnt_d;
      su_over_q <= su_over_d;
      iv_cnt_q  <= iv_cnt_d;
    end
  end

  assign startup_over = su_over_q;
  assign tick         = run && (iv_cnt_q == '0);

endmodule

// File: rtl/rfsh_backlog.sv
module rfsh_backlog #(
  parameter int DEPTH = 8,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          dec,
  output logic [LW-1:0] level
);
  logic [LW-1:0] level_q, level_d;

  always_comb begin
    level_d = level_q;
    unique case ({inc, dec})
      2'b10: if (level_q != LW'(DEPTH)) level_d = level_q + 1'b1;
      2'b01: if (level_q != '0)         level_d = level_q - 1'b1;
      default: level_d = level_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= '0;
    else        level_q <= level_d;
  end

  assign level = level_q;

endmodule

// File: rtl/rfsh_init_ctrl.sv
module rfsh_init_ctrl #(
  parameter int INIT_REFS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic startup_over,
  input  logic seq_idle,
  input  logic seq_done,
  output logic launch,
  output logic init_done
);
  localparam int IC_W = $clog2(INIT_REFS + 1);

  logic [IC_W-1:0] ic_q, ic_d;
  logic            done_q, done_d;

  always_comb begin
    ic_d   = ic_q;
    done_d = done_q;
    if (seq_done && !done_q) begin
      ic_d = ic_q + 1'b1;
      if (ic_q == IC_W'(INIT_REFS - 1)) done_d = 1'b1;
    end
  end

  // The cycle that carries a done pulse is skipped so that the count is
  // already updated before the next launch decision is taken.
  assign launch = startup_over && !done_q && seq_idle && !seq_done &&
                  (ic_q < IC_W'(INIT_REFS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ic_q   <= '0;
      done_q <= 1'b0;
    end else begin
      ic_q   <= ic_d;
      done_q <= done_d;
    end
  end

  assign init_done = done_q;

endmodule

// File: rtl/rfsh_strobe_seq.sv
module rfsh_strobe_seq
  import dram_rfsh_pkg::*;
#(
  parameter int SETUP_CYC = 1,
  parameter int HOLD_CYC  = 1,
  parameter int ACT_CYC   = 2,
  parameter int PRE_CYC   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic idle,
  output logic done,
  output logic ras_n,
  output logic cas_n
);
  localparam int MAXD  = max_int(max_int(SETUP_CYC, HOLD_CYC), max_int(ACT_CYC, PRE_CYC));
  localparam int CNT_W = $clog2(MAXD + 1);

  sq_state_e        st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ras_n_q, cas_n_q, done_q, done_d;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    done_d = 1'b0;
    unique case (st_q)
      SQ_IDLE: begin
        if (start) begin
          st_d  = SQ_SETUP;
          cnt_d = CNT_W'(SETUP_CYC - 1);
        end
      end
      SQ_SETUP: begin
        if (cnt_q == '0) begin
          st_d  = SQ_HOLD;
          cnt_d = CNT_W'(HOLD_CYC - 1);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      SQ_HOLD: begin
        if (cnt_q == '0) begin
          st_d  = SQ_ACT;
          cnt_d = CNT_W'(ACT_CYC - 1);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      SQ_ACT: begin
        if (cnt_q == '0) begin
          st_d  = SQ_PRE;
          cnt_d = CNT_W'(PRE_CYC - 1);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      SQ_PRE: begin
        if (cnt_q == '0) begin
          st_d   = SQ_IDLE;
          done_d = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SQ_IDLE;
      cnt_q   <= '0;
      ras_n_q <= 1'b1;
      cas_n_q <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      ras_n_q <= !((st_d == SQ_HOLD) || (st_d == SQ_ACT));
      cas_n_q <= !((st_d == SQ_SETUP) || (st_d == SQ_HOLD));
      done_q  <= done_d;
    end
  end

  assign idle  = (st_q == SQ_IDLE);
  assign done  = done_q;
  assign ras_n = ras_n_q;
  assign cas_n = cas_n_q;

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import dram_rfsh_pkg::*;
#(
  parameter int CLK_NS        = 20,
  parameter int STARTUP_NS    = 200000,
  parameter int INIT_REFS     = 8,
  parameter int ROWS          = 1024,
  parameter bit LOW_POWER     = 1'b0,
  parameter int WINDOW_STD_NS = 16000000,
  parameter int WINDOW_LP_NS  = 128000000,
  parameter int T_CSR_NS      = 5,
  parameter int T_CHR_NS      = 10,
  parameter int T_RAS_NS      = 50,
  parameter int T_RP_NS       = 30,
  parameter int T_RC_NS       = 90,
  parameter int T_RPC_NS      = 5,
  parameter int BACKLOG_MAX   = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rfsh_gnt,
  output logic rfsh_req,
  output logic rfsh_done,
  output logic init_done,
  output logic ras_n,
  output logic cas_n,
  output logic we_n
);
  localparam int WINDOW_NS    = LOW_POWER ? WINDOW_LP_NS : WINDOW_STD_NS;
  localparam int INTERVAL_CYC = WINDOW_NS / ROWS / CLK_NS;
  localparam int STARTUP_CYC  = max_int(ns_to_cyc(STARTUP_NS, CLK_NS), 1);
  localparam int SETUP_CYC    = max_int(ns_to_cyc(T_CSR_NS, CLK_NS), 1);
  localparam int HOLD_CYC     = max_int(ns_to_cyc(T_CHR_NS, CLK_NS), 1);
  localparam int RAS_CYC      = max_int(ns_to_cyc(T_RAS_NS, CLK_NS), HOLD_CYC + 1);
  localparam int ACT_CYC      = RAS_CYC - HOLD_CYC;
  localparam int PRE_CYC      = max_int(max_int(ns_to_cyc(T_RP_NS, CLK_NS),
                                                ns_to_cyc(T_RPC_NS, CLK_NS)),
                                        max_int(ns_to_cyc(T_RC_NS, CLK_NS) - RAS_CYC, 1));
  localparam int BLOG_W       = $clog2(BACKLOG_MAX + 1);

  logic [1:0]        rst_sync_q;
  logic              rst_n_int;
  logic              startup_over, tick, launch, seq_idle, seq_start, accept;
  logic              init_done_w, seq_done;
  logic [BLOG_W-1:0] blog_level;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  rfsh_interval_timer #(
    .STARTUP_CYC (STARTUP_CYC),
    .INTERVAL_CYC(INTERVAL_CYC)
  ) u_timer (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .run         (init_done_w),
    .startup_over(startup_over),
    .tick        (tick)
  );

  rfsh_backlog #(
    .DEPTH(BACKLOG_MAX)
  ) u_backlog (
    .clk  (clk),
    .rst_n(rst_n_int),
    .inc  (tick),
    .dec  (accept),
    .level(blog_level)
  );

  rfsh_init_ctrl #(
    .INIT_REFS(INIT_REFS)
  ) u_init (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .startup_over(startup_over),
    .seq_idle    (seq_idle),
    .seq_done    (seq_done),
    .launch      (launch),
    .init_done   (init_done_w)
  );

  rfsh_strobe_seq #(
    .SETUP_CYC(SETUP_CYC),
    .HOLD_CYC (HOLD_CYC),
    .ACT_CYC  (ACT_CYC),
    .PRE_CYC  (PRE_CYC)
  ) u_seq (
    .clk  (clk),
    .rst_n(rst_n_int),
    .start(seq_start),
    .idle (seq_idle),
    .done (seq_done),
    .ras_n(ras_n),
    .cas_n(cas_n)
  );

  assign rfsh_req  = init_done_w && seq_idle && (blog_level != '0);
  assign accept    = rfsh_req && rfsh_gnt;
  assign seq_start = launch || accept;
  assign rfsh_done = seq_done;
  assign init_done = init_done_w;
  assign we_n      = 1'b1;

endmodule

// File: rtl/dram_refresh_sched_chk.sv
module dram_refresh_sched_chk #(
  parameter int LW    = 4,
  parameter int DEPTH = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rfsh_gnt,
  input logic          rfsh_req,
  input logic          rfsh_done,
  input logic          init_done,
  input logic          ras_n,
  input logic          cas_n,
  input logic          we_n,
  input logic [LW-1:0] blog_level
);

  p_init_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  p_cas_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (!cas_n && !$past(cas_n)));

  p_cas_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cas_n) |-> (!ras_n && !$past(ras_n)));

  p_precharge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |-> (ras_n && $past(ras_n)));

  p_we_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> we_n);

  p_req_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rfsh_req |-> (init_done && (blog_level != '0) && ras_n && cas_n));

  p_backlog_cap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    blog_level <= LW'(DEPTH));

  p_handshake_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rfsh_req && rfsh_gnt) |=> $fell(cas_n));

  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rfsh_done |=> !rfsh_done);

endmodule

bind dram_refresh_sched dram_refresh_sched_chk #(
  .LW   (BLOG_W),
  .DEPTH(BACKLOG_MAX)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rfsh_gnt  (rfsh_gnt),
  .rfsh_req  (rfsh_req),
  .rfsh_done (rfsh_done),
  .init_done (init_done),
  .ras_n     (ras_n),
  .cas_n     (cas_n),
  .we_n      (we_n),
  .blog_level(blog_level)
);

// File: tb/sim_dram_refresh_sched.sv
module sim_dram_refresh_sched;
  // Scaled timing so that the run stays short: 100-cycle startup, 100-cycle interval
  localparam int CLK_NS     = 20;
  localparam int STARTUP_NS = 2000;
  localparam int ROWS       = 32;
  localparam int WIN_NS     = 64000;

  function automatic int cdiv(input int a, input int b);
    return (a + b - 1) / b;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int E_STARTUP = cdiv(STARTUP_NS, CLK_NS);
  localparam int E_SETUP   = mx(cdiv(5, CLK_NS), 1);
  localparam int E_CHR     = mx(cdiv(10, CLK_NS), 1);
  localparam int E_RAS     = mx(cdiv(50, CLK_NS), E_CHR + 1);
  localparam int E_RC      = cdiv(90, CLK_NS);
  localparam int E_RP      = mx(cdiv(30, CLK_NS), mx(E_RC - E_RAS, 1));
  localparam int E_INT     = WIN_NS / ROWS / CLK_NS;
  localparam int E_INIT    = 8;
  localparam int E_BLOG    = 8;

  logic clk, rst_n, gnt;
  logic req, done, idn, ras_n, cas_n, we_n;

  int  n_run, n_fail;
  bit  finished, rst_done, phase_a, counting_rel;

  dram_refresh_sched #(
    .CLK_NS       (CLK_NS),
    .STARTUP_NS   (STARTUP_NS),
    .ROWS         (ROWS),
    .LOW_POWER    (1'b0),
    .WINDOW_STD_NS(WIN_NS),
    .WINDOW_LP_NS (WIN_NS * 8)
  ) u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .rfsh_gnt (gnt),
    .rfsh_req (req),
    .rfsh_done(done),
    .init_done(idn),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .we_n     (we_n)
  );

  // 50 MHz with 1 ns time units
  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic void chk(input bit ok, input string rq, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endfunction

  // Falling-edge monitor
  int cyc, ras_low_run, cas_low_run, ras_high_run;
  int last_fall, last_casfall, init_cbr, first_cas, a_last, a_cnt, rel_count, cas_total;
  bit p_ras, p_cas, p_rg, p_done;

  initial begin
    cyc = 0; ras_low_run = 0; cas_low_run = 0; ras_high_run = 1000;
    last_fall = -1; last_casfall = -1000; init_cbr = 0; first_cas = -1;
    a_last = -1; a_cnt = 0; rel_count = 0; cas_total = 0;
    p_ras = 1'b1; p_cas = 1'b1; p_rg = 1'b0; p_done = 1'b0;
  end

  always @(negedge clk) begin
    if (rst_done && !finished) begin
      cyc++;
      if (p_cas && !cas_n) begin
        chk(ras_n && ras_high_run >= 1, "R4 ras high at cas fall", int'(ras_n), 1);
        if (idn) chk(p_rg, "R11 start without req&gnt", int'(p_rg), 1);
        if (!idn) init_cbr++;
        if (first_cas < 0) first_cas = cyc;
        last_casfall = cyc;
        cas_total++;
        if (counting_rel) rel_count++;
      end else if (p_rg) begin
        chk(1'b0, "R11 no start after req&gnt", int'(cas_n), 0);
      end
      if (p_ras && !ras_n) begin
        chk(!cas_n && cas_low_run >= E_SETUP, "R4 cas setup", cas_low_run, E_SETUP);
        chk(we_n, "R7 we at ras fall", int'(we_n), 1);
        if (last_fall >= 0) begin
          chk(ras_high_run >= E_RP, "R6 precharge", ras_high_run, E_RP);
          chk(cyc - last_fall >= E_RC, "R6 cycle", cyc - last_fall, E_RC);
        end
        if (phase_a) begin
          if (a_last >= 0) chk(cyc - a_last <= E_INT, "R8 gap", cyc - a_last, E_INT);
          a_last = cyc;
          a_cnt++;
        end
        last_fall = cyc;
      end
      if (!p_ras && ras_n) chk(ras_low_run == E_RAS, "R5 ras width", ras_low_run, E_RAS);
      if (!p_cas && cas_n) chk(!ras_n && ras_low_run >= E_CHR, "R5 cas hold", ras_low_run, E_CHR);
      if (done) begin
        chk(!p_done, "R12 done width", int'(p_done), 0);
        chk(cyc - last_casfall == E_SETUP + E_RAS + E_RP, "R12 done timing",
            cyc - last_casfall, E_SETUP + E_RAS + E_RP);
      end
      if (req && !idn) chk(1'b0, "R9 req before init", int'(req), 0);
      ras_low_run  = ras_n ? 0 : ras_low_run + 1;
      ras_high_run = ras_n ? ras_high_run + 1 : 0;
      cas_low_run  = cas_n ? 0 : cas_low_run + 1;
      p_ras  = ras_n;
      p_cas  = cas_n;
      p_rg   = req && gnt;
      p_done = done;
    end
  end

  task automatic drive_gnt(input logic v);
    @(posedge clk);
    #2 gnt = v;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #4000000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int t0, cas_before;
    void'($urandom(32'd4711));
    n_run = 0; n_fail = 0; finished = 1'b0; rst_done = 1'b0;
    phase_a = 1'b0; counting_rel = 1'b0;
    rst_n = 1'b0; gnt = 1'b0;
    repeat (4) @(negedge clk);
    chk(ras_n && cas_n && we_n, "R1 strobes in reset", {ras_n, cas_n, we_n}, 7);
    chk(!req && !done && !idn, "R1 flags in reset", {req, done, idn}, 0);
    @(posedge clk);
    #2 rst_n = 1'b1;
    rst_done = 1'b1;

    // Initialization runs with the grant low (R3)
    for (int i = 0; i < 20000 && !idn; i++) @(negedge clk);
    t0 = cyc;
    chk(idn, "R3 init_done rose", int'(idn), 1);
    chk(init_cbr == E_INIT, "R3 wake-up count", init_cbr, E_INIT);
    chk(first_cas >= E_STARTUP, "R2 startup delay", first_cas, E_STARTUP);
    chk(!req, "R9 idle after init", int'(req), 0);

    // Phase A: grant held, interval bound (R8)
    drive_gnt(1'b1);
    phase_a = 1'b1;
    repeat (10 * E_INT) @(posedge clk);
    phase_a = 1'b0;
    chk(a_cnt >= 9, "R8 count in ten intervals", a_cnt, 9);
    chk(idn, "R3 init_done sticky", int'(idn), 1);

    // Phase B: grant withheld, backlog saturates (R9, R10)
    drive_gnt(1'b0);
    repeat (3) @(negedge clk);
    cas_before = cas_total;
    repeat (12 * E_INT) @(negedge clk);
    chk(cas_total == cas_before, "R9 no refresh without grant", cas_total - cas_before, 0);
    chk(req, "R9 req pending", int'(req), 1);
    while (((cyc - t0) % E_INT) != 20) @(negedge clk);
    drive_gnt(1'b1);
    counting_rel = 1'b1;
    repeat (70) @(negedge clk);
    counting_rel = 1'b0;
    chk(rel_count == E_BLOG, "R10 drained backlog", rel_count, E_BLOG);
    chk(!req, "R10 req after drain", int'(req), 0);

    // Phase C: random grant (R11, R12 via monitor)
    for (int i = 0; i < 30 * E_INT; i++) begin
      @(posedge clk);
      #2 gnt = ($urandom % 2) == 0;
    end
    drive_gnt(1'b1);
    repeat (2 * E_INT) @(negedge clk);
    chk(idn, "R3 init_done at end", int'(idn), 1);
    finish_run();
  end

endmodule